// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This unit watches a running BCD calendar (seconds, minutes, hours with a PM indicator, day of month and weekday) and raises a sticky alarm flag when the calendar reaches a programmed alarm word. Each compared field has its own ignore bit. The day field can compare against either the day of month or the weekday. Month and year are never compared. The calendar counters live outside the unit. Their current values are presented on inputs, together with a one-cycle `tick` strobe each time they advance.

Software reaches the unit through a simple write port with three targets: a control register, the alarm word, and a clear register. The alarm word may only be changed while the alarm is disabled, and only after a write-permit flag has risen. That flag rises a set number of slow-clock strobes after the disable. The interrupt output is the flag gated by an interrupt enable.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, the alarm enable, interrupt enable, alarm flag, write-permit flag, alarm word and interrupt output are all zero.
- R2: Alarm word bits 6:0 hold the BCD seconds and bits 14:8 hold the BCD minutes. Bit 7 set makes the seconds ignored, and bit 15 set makes the minutes ignored.
- R3: Bits 21:16 hold the BCD hour and bit 22 the PM indicator. Both must equal the calendar unless bit 23 is set, in which case the hour is ignored.
- R4: With bit 30 clear, bits 29:24 are compared with the day of month. With bit 30 set, bits 27:24 are compared with the zero-extended 3-bit weekday. Bit 31 set makes the day ignored.
- R5: Writes select a target with `wr_sel`: 0 selects control, 1 the alarm word, 2 the clear register. Control bit 0 is the alarm enable and bit 1 is the interrupt enable. The write-permit flag drops in the cycle the alarm enable is written to 1. While the enable stays clear, the flag rises on the SYNC_TICKS-th `slow_ce` strobe.
- R6: An alarm word write is ignored unless the write-permit flag is set and the alarm is disabled.
- R7: The flag is set by a `tick` at which all unignored fields match and the previous tick did not match. It is not set while the alarm enable is clear.
- R8: `irq` is high exactly while the flag and the interrupt enable are both set.
- R9: Writing the clear register with bit 0 set clears the flag, and writing it with bit 0 clear does not. A new match in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_ce | input | 1 | Slow-clock strobe used by the write-permit delay |
| tick | input | 1 | Calendar advanced; inputs below are valid |
| cal_sec | input | 7 | BCD seconds |
| cal_min | input | 7 | BCD minutes |
| cal_hour | input | 6 | BCD hour |
| cal_pm | input | 1 | PM indicator |
| cal_mday | input | 6 | BCD day of month |
| cal_wday | input | 3 | Weekday 1..7 |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target (0 control, 1 alarm word, 2 clear) |
| wr_data | input | 32 | Write data |
| alarm_word | output | 32 | Current alarm word |
| alarm_en | output | 1 | Alarm enable |
| alarm_ie | output | 1 | Interrupt enable |
| wr_allowed | output | 1 | Write-permit flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the unit with the default SYNC_TICKS of 2. With that value, the write-permit delay can be probed one strobe short of its end and exactly at its end in a few cycles. That leaves room to walk each field mask, the PM bit, both day-select modes and the full day mask, each followed by a clear. It also reaches the fire-once rule and the case where a clear and a match land in the same cycle.

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int SYNC_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_ce,
  input  logic        tick,
  input  logic [6:0]  cal_sec,
  input  logic [6:0]  cal_min,
  input  logic [5:0]  cal_hour,
  input  logic        cal_pm,
  input  logic [5:0]  cal_mday,
  input  logic [2:0]  cal_wday,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] alarm_word,
  output logic        alarm_en,
  output logic        alarm_ie,
  output logic        wr_allowed,
  output logic        alarm_flag,
  output logic        irq
);
  localparam int CW = $clog2(SYNC_TICKS + 1);

  logic [31:0]   word_q;
  logic          en_q, ie_q, wa_q, flag_q, prev_q;
  logic [CW-1:0] cnt_q;

  wire wr_ctrl = wr_en && (wr_sel == 2'd0);
  wire wr_word = wr_en && (wr_sel == 2'd1);
  wire wr_clr  = wr_en && (wr_sel == 2'd2);

  wire sec_ok = word_q[7]  | (word_q[6:0] == cal_sec);
  wire min_ok = word_q[15] | (word_q[14:8] == cal_min);
  wire hr_ok  = word_q[23] | ((word_q[21:16] == cal_hour) && (word_q[22] == cal_pm));
  wire day_ok = word_q[31] | (word_q[30] ? (word_q[27:24] == {1'b0, cal_wday})
                                         : (word_q[29:24] == cal_mday));
  wire hit    = sec_ok & min_ok & hr_ok & day_ok;
  wire fire   = tick & hit & ~prev_q & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= wr_data[0];
      ie_q <= wr_data[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || en_q || (wr_ctrl && wr_data[0])) begin
      wa_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!wa_q && slow_ce) begin
      if (cnt_q == CW'(SYNC_TICKS - 1)) wa_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else if (wr_word && wa_q && !en_q) word_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (tick) prev_q <= hit;
      if (fire) flag_q <= 1'b1;
      else if (wr_clr && wr_data[0]) flag_q <= 1'b0;
    end
  end

  assign alarm_word = word_q;
  assign alarm_en   = en_q;
  assign alarm_ie   = ie_q;
  assign wr_allowed = wa_q;
  assign alarm_flag = flag_q;
  assign irq        = flag_q & ie_q;

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick && en_q));
  assert_word_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> $past(wa_q && !en_q && wr_word));
  assert_permit_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wa_q) |-> ($past(slow_ce) && !en_q));
  assert_permit_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> !wa_q);
  assert_clear_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_clr && wr_data[0]));
endmodule

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, slow_ce = 1'b0, tick = 1'b0;
  logic [6:0] cal_sec = '0, cal_min = '0;
  logic [5:0] cal_hour = '0, cal_mday = '0;
  logic cal_pm = 1'b0;
  logic [2:0] cal_wday = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] alarm_word;
  logic alarm_en, alarm_ie, wr_allowed, alarm_flag, irq;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { int id; logic [31:0] exp; string req; } item_t;
  item_t sb[$];

  always #(CLK_NS/2) clk = ~clk;

  cal_alarm_match #(.SYNC_TICKS(2)) i_cal_alarm_match (
    .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce), .tick(tick),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour), .cal_pm(cal_pm),
    .cal_mday(cal_mday), .cal_wday(cal_wday),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .alarm_word(alarm_word), .alarm_en(alarm_en), .alarm_ie(alarm_ie),
    .wr_allowed(wr_allowed), .alarm_flag(alarm_flag), .irq(irq));

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.id)
        0: act = {31'd0, alarm_flag};
        1: act = {31'd0, irq};
        2: act = {31'd0, wr_allowed};
        3: act = alarm_word;
        default: act = {31'd0, alarm_en};
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s item %0d actual=%h expected=%h", it.req, it.id, act, it.exp);
      end
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic expect_item(input int id, input logic [31:0] v, input string r);
    item_t it;
    it.id = id; it.exp = v; it.req = r;
    sb.push_back(it);
  endtask
  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d; step();
    wr_en = 1'b0; wr_data = '0;
  endtask
  task automatic tk(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                    input logic p, input logic [5:0] md, input logic [2:0] wd);
    cal_sec = s; cal_min = m; cal_hour = h; cal_pm = p; cal_mday = md; cal_wday = wd;
    tick = 1'b1; step(); tick = 1'b0;
  endtask
  task automatic slow(); slow_ce = 1'b1; step(); slow_ce = 1'b0; endtask
  task automatic reprogram(input logic [31:0] w, input logic [31:0] ctrl);
    wr(2'd0, 32'd0); slow(); slow(); wr(2'd1, w); wr(2'd0, ctrl);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    expect_item(0, 0, "R1"); expect_item(1, 0, "R1"); expect_item(2, 0, "R1");
    expect_item(3, 0, "R1"); expect_item(4, 0, "R1");
    step();
    // R6: word write before permit is ignored
    wr(2'd1, 32'h12101530); expect_item(3, 0, "R6");
    // R5: permit after two slow strobes
    slow(); expect_item(2, 0, "R5");
    slow(); expect_item(2, 1, "R5");
    wr(2'd1, 32'h12101530); expect_item(3, 32'h12101530, "R2");
    wr(2'd0, 32'd3); expect_item(4, 1, "R5"); expect_item(2, 0, "R5");
    // R2: seconds mismatch, then match
    tk(7'h29, 7'h15, 6'h10, 0, 6'h12, 3'd3); expect_item(0, 0, "R2");
    tk(7'h30, 7'h15, 6'h10, 0, 6'h12, 3'd3); expect_item(0, 1, "R7"); expect_item(1, 1, "R8");
    // R9: clear semantics
    wr(2'd2, 32'd0); expect_item(0, 1, "R9");
    wr(2'd2, 32'd1); expect_item(0, 0, "R9"); expect_item(1, 0, "R8");
    // R7: no refire while still matching
    tk(7'h30, 7'h15, 6'h10, 0, 6'h12, 3'd3); expect_item(0, 0, "R7");
    tk(7'h30, 7'h16, 6'h10, 0, 6'h12, 3'd3); expect_item(0, 0, "R2");
    tk(7'h30, 7'h15, 6'h10, 0, 6'h12, 3'd3); expect_item(0, 1, "R2");
    wr(2'd2, 32'd1);
    // R7: disabled alarm never sets flag
    wr(2'd0, 32'd0); slow(); slow(); expect_item(2, 1, "R5");
    tk(7'h31, 7'h15, 6'h10, 0, 6'h12, 3'd3);
    tk(7'h30, 7'h15, 6'h10, 0, 6'h12, 3'd3); expect_item(0, 0, "R7");
    // R3: hour with PM
    wr(2'd1, 32'h80478080); expect_item(3, 32'h80478080, "R3");
    wr(2'd0, 32'd1);
    tk(7'h00, 7'h00, 6'h07, 0, 6'h01, 3'd1); expect_item(0, 0, "R3");
    tk(7'h01, 7'h00, 6'h07, 1, 6'h01, 3'd1); expect_item(0, 1, "R3"); expect_item(1, 0, "R8");
    wr(2'd0, 32'd3); expect_item(1, 1, "R8");
    wr(2'd2, 32'd1);
    // R4: weekday select
    reprogram(32'h43808080, 32'd1);
    tk(7'h00, 7'h00, 6'h01, 0, 6'h03, 3'd2); expect_item(0, 0, "R4");
    tk(7'h01, 7'h00, 6'h01, 0, 6'h09, 3'd3); expect_item(0, 1, "R4");
    wr(2'd2, 32'd1);
    // R4: day of month
    reprogram(32'h25808080, 32'd1);
    tk(7'h00, 7'h00, 6'h01, 0, 6'h24, 3'd5); expect_item(0, 0, "R4");
    tk(7'h01, 7'h00, 6'h01, 0, 6'h25, 3'd5); expect_item(0, 1, "R4");
    wr(2'd2, 32'd1);
    // R4: day fully masked, seconds compared
    reprogram(32'h80808005, 32'd1);
    tk(7'h04, 7'h44, 6'h13, 1, 6'h31, 3'd7); expect_item(0, 0, "R4");
    tk(7'h05, 7'h44, 6'h13, 1, 6'h31, 3'd7); expect_item(0, 1, "R4");
    wr(2'd2, 32'd1); expect_item(0, 0, "R9");
    tk(7'h04, 7'h00, 6'h01, 0, 6'h01, 3'd1);
    // R9: match wins over same-cycle clear
    cal_sec = 7'h05; tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'd1;
    step();
    tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    expect_item(0, 1, "R9");
    step(); step();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule